// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets software reach the management registers of PHYs over a two-wire MDIO bus. Software first programs the target PHY and register number. It then starts a transaction by writing a register, and polls status flags until the frame has finished. For a read, software collects the 16-bit result from a dedicated read-data register. The block produces the MDC clock by dividing the system clock. It drives the MDIO line through a separate output value and output enable, so that a pad tristate can be built outside.

There are six 32-bit word registers, selected by byte address bits 4:2:

- Configuration: clock divider select, plus a self-clearing abort bit.
- Command: the read trigger.
- Address: the PHY address and register number.
- Write data.
- Read data.
- Indication: the BUSY and NOTVALID flags.

Every frame is 64 MDC cycles long. It starts with a 32-bit preamble and a start code. Then come the opcode, the PHY address and the register number. It ends with a turnaround and the 16 data bits.

Top module: `mdio_master`

## Requirements
- R1: Byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 select the configuration, command, address, write-data, read-data and indication registers. The address register reads back the PHY address in bits 12:8 and the register number in bits 4:0, with all other bits zero. The configuration register reads back only its divider field, in bits 2:0.
- R2: A bus write to the write-data register latches bits 15:0 and starts a write frame when the block is idle. From the next clock, indication bit 0 (BUSY) reads 1.
- R3: A write frame carries, MSB first, 32 ones, then 01, then opcode 01, then the 5-bit PHY address, the 5-bit register number, turnaround 10 and the 16 data bits. The output enable is held high for all 64 bits. MDIO changes only on a falling MDC edge.
- R4: A read frame starts only when a bus write takes command bit 0 from 0 to 1. Writing 1 again while the bit is already 1 starts nothing.
- R5: A read frame sends 32 ones, 01, opcode 10, the PHY address and the register number. The output enable drops from bit 46 (the turnaround) to the end of the frame. The block samples 16 data bits, MSB first, on the rising MDC edges of bits 48 to 63, and places them in read-data bits 15:0.
- R6: Indication bit 2 (NOTVALID) is set when a read starts and is cleared when the read data is captured. BUSY clears when the frame ends.
- R7: The configuration field in bits 2:0 selects an MDC period of 4, 4, 6, 8, 10, 14, 20 or 28 system clocks for the values 0 to 7. The field resets to 7. MDC is low whenever the block is idle.
- R8: Writing 1 to configuration bit 31 aborts any frame. BUSY and NOTVALID read 0 from the next clock. MDC and the output enable are low one clock after that.
- R9: While BUSY is set, new write-data writes and command 0-to-1 writes are ignored. Read data keeps its value until the next read completes.
- R10: After reset, every register reads 0 except the configuration register, which reads 7. MDC and the output enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | MDIO value sampled from the pad |
| mdio_o | output | 1 | MDIO value driven to the pad |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The assertions watch, on every cycle, the properties that need no knowledge of a frame's content. MDC stays low while idle. MDIO holds steady between falling MDC edges. NOTVALID never stands without BUSY. A frame begins only after a register write. Read data moves only when NOTVALID falls. An abort or frame end leaves MDC and the output enable low. Only the bench scenarios can show the following: the exact bit order of both frame types, the turnaround release point, the MDC period for each divider code, edge-triggered read starts, requests ignored while busy, and recovery after an abort. The bench shows these by capturing the line with a PHY model on each rising MDC edge.

// File: rtl/mdio_pkg.sv
// Package: shared register indices, frame geometry and the divider table
// for the MDIO management master. Assumes word-aligned register access.
package mdio_pkg;
    localparam int REG_AW     = 5;
    localparam int DIV_W      = 3;
    localparam int CNT_W      = 4;
    localparam int FRAME_BITS = 64;
    localparam int TA_BIT     = 46;
    localparam int DATA_BIT   = 48;
    localparam int FRM_IDX_W  = $clog2(FRAME_BITS);

    localparam logic [2:0] IDX_CFG = 3'd0;
    localparam logic [2:0] IDX_CMD = 3'd1;
    localparam logic [2:0] IDX_ADR = 3'd2;
    localparam logic [2:0] IDX_WDT = 3'd3;
    localparam logic [2:0] IDX_RDT = 3'd4;
    localparam logic [2:0] IDX_IND = 3'd5;

    // Half of the MDC period, in system clocks, for each divider code.
    function automatic logic [CNT_W-1:0] half_div(input logic [DIV_W-1:0] sel);
        case (sel)
            3'd0, 3'd1: half_div = 4'd2;
            3'd2:       half_div = 4'd3;
            3'd3:       half_div = 4'd4;
            3'd4:       half_div = 4'd5;
            3'd5:       half_div = 4'd7;
            3'd6:       half_div = 4'd10;
            default:    half_div = 4'd14;
        endcase
    endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
// MDC generator: while run is high, toggles mdc every half period.
// Emits single-cycle rise/fall strobes on the clock where mdc changes.
// Assumes sel may change at any time; the >= compare tolerates a shrink.
module mdio_clkdiv
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] sel,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [CNT_W-1:0] cnt;
    logic             wrap;

    assign wrap = run && (cnt >= (half_div(sel) - 4'd1));
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    // Count half periods and toggle mdc; hold everything low while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 4'd1;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer: loads a 64-bit frame on a start strobe and shifts it
// out one bit per falling MDC edge. For reads, it releases the line from
// the turnaround onward and samples data on rising edges.
// Assumes start_wr and start_rd are never high together.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        abort,
    input  logic        start_wr,
    input  logic        start_rd,
    input  logic [4:0]  phy,
    input  logic [4:0]  regn,
    input  logic [15:0] wdata,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_i,
    output logic        busy,
    output logic        notvalid,
    output logic [15:0] rd_data,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic [FRAME_BITS-1:0] shreg;
    logic [FRM_IDX_W-1:0]  bitk;
    logic                  is_rd;
    logic [15:0]           rx;
    logic                  last;

    assign last    = fall && (bitk == FRM_IDX_W'(FRAME_BITS - 1));
    assign mdio_o  = busy ? shreg[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = busy && !(is_rd && (bitk >= FRM_IDX_W'(TA_BIT)));

    // Frame control: start, shift on falling MDC, finish or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            notvalid <= 1'b0;
            is_rd    <= 1'b0;
            bitk     <= '0;
            shreg    <= '1;
            rd_data  <= '0;
        end else if (abort) begin
            busy     <= 1'b0;
            notvalid <= 1'b0;
        end else if (!busy && (start_wr || start_rd)) begin
            busy     <= 1'b1;
            is_rd    <= start_rd;
            notvalid <= start_rd;
            bitk     <= '0;
            shreg    <= {32'hFFFF_FFFF, 2'b01, (start_rd ? 2'b10 : 2'b01),
                         phy, regn, 2'b10, (start_rd ? 16'h0000 : wdata)};
        end else if (busy && fall) begin
            bitk  <= bitk + 1'b1;
            shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
            if (last) begin
                busy <= 1'b0;
                if (is_rd) begin
                    notvalid <= 1'b0;
                    rd_data  <= rx;
                end
            end
        end
    end

    // Sample the read data on rising MDC during the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx <= '0;
        end else if (busy && is_rd && rise && (bitk >= FRM_IDX_W'(DATA_BIT))) begin
            rx <= {rx[14:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_regs.sv
// Register bank: decodes word writes, holds configuration, command,
// address and write data, and turns bus writes into start/abort strobes.
// Assumes a single-cycle write strobe; reads are combinational.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_RESET = 3'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              busy,
    input  logic              notvalid,
    input  logic [15:0]       rd_data,
    output logic [31:0]       rdata,
    output logic [DIV_W-1:0]  div_sel,
    output logic [4:0]        phy,
    output logic [4:0]        regn,
    output logic              start_wr,
    output logic              start_rd,
    output logic              abort
);
    logic [2:0]  idx;
    logic        cmd_bit;
    logic [15:0] wr_q;
    logic        unused_bits;

    assign idx         = addr[4:2];
    assign unused_bits = ^{addr[1:0], wdata[30:16]};
    assign abort       = we && (idx == IDX_CFG) && wdata[31];
    assign start_wr    = we && (idx == IDX_WDT) && !busy;
    assign start_rd    = we && (idx == IDX_CMD) && wdata[0] && !cmd_bit && !busy;

    // Hold the software-written registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_sel <= DIV_RESET;
            cmd_bit <= 1'b0;
            phy     <= '0;
            regn    <= '0;
            wr_q    <= '0;
        end else if (we) begin
            case (idx)
                IDX_CFG: div_sel <= wdata[DIV_W-1:0];
                IDX_CMD: cmd_bit <= wdata[0];
                IDX_ADR: begin
                    phy  <= wdata[12:8];
                    regn <= wdata[4:0];
                end
                IDX_WDT: if (!busy) wr_q <= wdata[15:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        case (idx)
            IDX_CFG: rdata = {{(32-DIV_W){1'b0}}, div_sel};
            IDX_CMD: rdata = {31'd0, cmd_bit};
            IDX_ADR: rdata = {19'd0, phy, 3'd0, regn};
            IDX_WDT: rdata = {16'd0, wr_q};
            IDX_RDT: rdata = {16'd0, rd_data};
            IDX_IND: rdata = {29'd0, notvalid, 1'b0, busy};
            default: rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/mdio_master.sv
// Top: MDIO management master. Connects the register bank, the MDC
// divider and the frame sequencer. The pad tristate is built outside.
module mdio_master
    import mdio_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_RESET = 3'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic             busy, notvalid, start_wr, start_rd, abort, rise, fall;
    logic [15:0]      rd_data;
    logic [DIV_W-1:0] div_sel;
    logic [4:0]       phy, regn;

    mdio_regs #(.DIV_RESET(DIV_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .notvalid(notvalid), .rd_data(rd_data), .rdata(reg_rdata),
        .div_sel(div_sel), .phy(phy), .regn(regn),
        .start_wr(start_wr), .start_rd(start_rd), .abort(abort)
    );

    mdio_clkdiv u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .sel(div_sel),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_frame_seq u_seq (
        .clk(clk), .rst_n(rst_n), .abort(abort), .start_wr(start_wr),
        .start_rd(start_rd), .phy(phy), .regn(regn), .wdata(reg_wdata[15:0]),
        .rise(rise), .fall(fall), .mdio_i(mdio_i), .busy(busy),
        .notvalid(notvalid), .rd_data(rd_data), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Checker for mdio_master: cycle-level protocol properties, bound to the
// top so that it observes the sequencer state next to the pins.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic        busy,
    input logic        notvalid,
    input logic [15:0] rd_data,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    p_mdc_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !mdc);

    p_mdio_moves_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

    p_notvalid_inside_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        notvalid |-> busy);

    p_start_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(notvalid) |-> $stable(rd_data));

    p_quiet_after_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> (!mdc && !mdio_oe));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .busy(busy),
    .notvalid(notvalid), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    localparam int CLK_P = 10;
    localparam int NVEC  = 6;
    // {read, phy, reg, data/response, divider code}
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b0, 5'h01, 5'h00, 16'hA5C3, 3'd0},
        {1'b1, 5'h1F, 5'h1F, 16'hBEEF, 3'd7},
        {1'b0, 5'h15, 5'h0A, 16'hFFFF, 3'd3},
        {1'b1, 5'h0A, 5'h15, 16'h1234, 3'd1},
        {1'b1, 5'h00, 5'h00, 16'h8001, 3'd6},
        {1'b0, 5'h10, 5'h01, 16'h0000, 3'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;
    int          n_chk = 0;
    int          n_fail = 0;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic int ratio_of(input logic [2:0] s);
        case (s)
            3'd0, 3'd1: return 4;
            3'd2: return 6;
            3'd3: return 8;
            3'd4: return 10;
            3'd5: return 14;
            3'd6: return 20;
            default: return 28;
        endcase
    endfunction

    // One complete frame with a PHY model; meddle adds requests while busy.
    task automatic run_frame(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] data, input logic [2:0] dv, input bit meddle);
        logic [63:0] exp, cap, oecap, oeexp;
        logic [31:0] v, old_rd;
        time t1, t2;
        int  wait_n;
        t1 = 0; t2 = 0; cap = '0; oecap = '0;
        rd_reg(5'h10, old_rd);
        bus_wr(5'h00, {29'd0, dv});
        bus_wr(5'h08, {19'd0, phy, 3'd0, rg});
        mdio_i = 1'b1;
        if (rd) begin
            bus_wr(5'h04, 32'd0);
            bus_wr(5'h04, 32'd1);
        end else begin
            bus_wr(5'h0C, {16'hDEAD, data});
        end
        rd_reg(5'h14, v);
        chk("R2 busy set after start", {63'd0, v[0]}, 64'd1);
        chk("R6 notvalid at start", {63'd0, v[2]}, {63'd0, rd});
        for (int k = 0; k < 64; k++) begin
            @(posedge mdc);
            cap[63-k]   = mdio_o;
            oecap[63-k] = mdio_oe;
            if (k == 0) t1 = $time;
            if (k == 1) t2 = $time;
            if ((k + 1 >= 48) && (k + 1 <= 63)) mdio_i = data[62-k];
            else mdio_i = 1'b1;
            if (meddle && k == 5) begin
                bus_wr(5'h0C, 32'h0000_0F0F);
                bus_wr(5'h04, 32'd0);
                bus_wr(5'h04, 32'd1);
                rd_reg(5'h14, v);
                chk("R9 read request ignored while busy", {61'd0, v[2:0]}, 64'd1);
            end
        end
        wait_n = 0;
        do begin
            @(negedge clk);
            rd_reg(5'h14, v);
            wait_n++;
        end while (v[0] && wait_n < 40);
        exp = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, data};
        oeexp = rd ? {{46{1'b1}}, 18'd0} : '1;
        if (rd) begin
            chk("R5 read frame header", {18'd0, cap[63:18]}, {18'd0, exp[63:18]});
            chk("R5 read output enable", oecap, oeexp);
        end else begin
            chk("R3 write frame bits", cap, exp);
            chk("R3 write output enable", oecap, oeexp);
        end
        chk("R7 mdc period", 64'(int'((t2 - t1) / CLK_P)), 64'(ratio_of(dv)));
        chk("R6 flags clear at end", {61'd0, v[2:0]}, 64'd0);
        rd_reg(5'h10, v);
        if (rd) chk("R5 read data captured", {32'd0, v}, {48'd0, data});
        else    chk("R9 read data held over write", {32'd0, v}, {32'd0, old_rd});
        chk("R7 mdc idle low", {63'd0, mdc}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        rd_reg(5'h00, v); chk("R10 cfg reset", {32'd0, v}, 64'd7);
        rd_reg(5'h04, v); chk("R10 cmd reset", {32'd0, v}, 64'd0);
        rd_reg(5'h08, v); chk("R10 addr reset", {32'd0, v}, 64'd0);
        rd_reg(5'h10, v); chk("R10 rdata reset", {32'd0, v}, 64'd0);
        rd_reg(5'h14, v); chk("R10 ind reset", {32'd0, v}, 64'd0);
        chk("R10 pins idle", {62'd0, mdc, mdio_oe}, 64'd0);
        // R1: field positions and readback
        bus_wr(5'h08, 32'hFFFF_FFFF);
        rd_reg(5'h08, v); chk("R1 addr fields", {32'd0, v}, 64'h1F1F);
        bus_wr(5'h00, 32'h0000_0FF5);
        rd_reg(5'h00, v); chk("R1 cfg divider field", {32'd0, v}, 64'd5);
        // Vector table: frames of both kinds across divider codes.
        for (int i = 0; i < NVEC; i++)
            run_frame(VEC[i][29], VEC[i][28:24], VEC[i][23:19], VEC[i][18:3], VEC[i][2:0], 1'b0);
        // R4: command bit already 1, writing 1 again starts nothing.
        bus_wr(5'h04, 32'd1);
        repeat (3) @(negedge clk);
        rd_reg(5'h14, v); chk("R4 no start without 0-to-1", {32'd0, v}, 64'd0);
        chk("R4 mdc stays low", {63'd0, mdc}, 64'd0);
        // R9: requests while busy are ignored; data sent is the original.
        run_frame(1'b0, 5'h03, 5'h04, 16'h5A5A, 3'd7, 1'b1);
        // R8: abort in mid-read.
        rd_reg(5'h10, held);
        bus_wr(5'h04, 32'd0);
        bus_wr(5'h04, 32'd1);
        repeat (100) @(negedge clk);
        rd_reg(5'h14, v); chk("R8 busy before abort", {61'd0, v[2:0]}, 64'd5);
        bus_wr(5'h00, 32'h8000_0007);
        rd_reg(5'h14, v); chk("R8 flags cleared by abort", {32'd0, v}, 64'd0);
        @(negedge clk);
        chk("R8 line idle after abort", {62'd0, mdc, mdio_oe}, 64'd0);
        rd_reg(5'h10, v); chk("R8 read data kept", {32'd0, v}, {32'd0, held});
        rd_reg(5'h00, v); chk("R8 abort bit not stored", {32'd0, v}, 64'd7);
        // Recovery after abort.
        run_frame(1'b0, 5'h07, 5'h02, 16'hC0DE, 3'd0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule